// File: doc/BRIEF.md
# Lockable Memory Region Register Bank

This block holds the start and end addresses of three protected memory windows. It sits as a target on an internal message bus and answers only to messages that carry its own port number. Each window has two 32-bit registers, a start register and an end register. Addresses are kept at 16-byte granularity, so the bottom four bits of a written value are not stored as address bits.

A window can be sealed. Writing the start register with its bottom four bits all zero stores the address and sets that window's lock flag. From then on, any write to that window is dropped. Only a reset clears the flag. The third window is normally kept for a security coprocessor. The bank drives each window's start, end and lock state on dedicated outputs, which the access-checking logic further downstream uses.

Reads come back one cycle after the request, with the lock flag placed in bit 0. Offsets that decode to no register read as zero. Writes to such offsets do nothing.

Top module: `lrb_bank`

## Requirements
- R1: While reset is held, and on the first cycle after it, every lock flag is 0, every start and end output is zero, and `rsp_valid` is low.
- R2: A message whose `msg_port` differs from 0x03 changes no register and produces no response.
- R3: Window k (k = 0, 1, 2) has its start register at offset 0x10+2k and its end register at 0x11+2k. A write to either one updates the matching output on the next cycle. The output holds the written value with bits [3:0] forced to zero.
- R4: A read accepted in cycle t raises `rsp_valid` in cycle t+1. `rsp_rdata` then equals the stored address bits [31:4], zeros in bits [3:1], and the window's lock flag in bit 0.
- R5: A write to a start register whose data bits [3:0] are all zero stores the address and sets that window's lock flag. Both take effect on the next cycle.
- R6: A write to a start register whose data bits [3:0] are nonzero updates the address and leaves the lock flag clear.
- R7: While a window is locked, writes to its start or end register are discarded. The other windows stay writable.
- R8: A set lock flag never clears, even after further writes with nonzero bits [3:0]. Only reset clears it.
- R9: Offsets outside 0x10..0x15 return zero data with `rsp_valid` high, and writes to them change no output.
- R10: A write never raises `rsp_valid` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Message present this cycle |
| msg_write | input | 1 | 1 for a write, 0 for a read |
| msg_port | input | 8 | Destination port of the message |
| msg_offset | input | 8 | Register offset within the port |
| msg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after the read |
| rsp_rdata | output | 32 | Read response data |
| rgn_base | output | 96 | Start address of each window, 32 bits per window, window 0 in the low bits |
| rgn_end | output | 96 | End address of each window, same packing |
| rgn_locked | output | 3 | Lock flag for each window |

## Verification
The bench first locks window 1 by writing a zero bottom nibble to its start register. It then tries to overwrite both of that window's registers. A design that kept accepting writes after the lock, or that froze only the start register, would show a changed end output. A second write with a nonzero nibble probes whether the lock is really sticky; a design that recomputed the flag from the last write would drop it there. Offsets just beside the map (0x0F and 0x16) and a message aimed at a neighbouring port catch decoders that alias or ignore the port field. A final reset confirms that the lock flags and the addresses both clear.

// File: rtl/lrb_pkg.sv
`timescale 1ns/1ps
package lrb_pkg;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 8;
    localparam int PORT_W = 8;
    localparam int TAG_W  = 4;
    localparam int ADR_W  = DATA_W - TAG_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADR_W-1:0]  adr_t;

    typedef struct packed {
        logic              wr;
        logic [PORT_W-1:0] port;
        logic [OFF_W-1:0]  off;
    } req_t;

    typedef struct packed {
        logic             acc;
        logic             hit;
        logic             high;
        logic [OFF_W-2:0] idx;
    } sel_t;

    function automatic logic is_lock_tag(input logic [TAG_W-1:0] tag);
        return tag == '0;
    endfunction

    function automatic word_t to_word(input adr_t a);
        return {a, {TAG_W{1'b0}}};
    endfunction

    function automatic word_t pack_read(input adr_t a, input logic lk);
        return {a, {(TAG_W-1){1'b0}}, lk};
    endfunction
endpackage

// File: rtl/lrb_decode.sv
`timescale 1ns/1ps
module lrb_decode
    import lrb_pkg::*;
#(
    parameter int                NUM_RGN   = 3,
    parameter logic [PORT_W-1:0] BANK_PORT = 8'h03,
    parameter logic [OFF_W-1:0]  BASE_OFF  = 8'h10
) (
    input  logic               valid,
    input  req_t               req,
    output logic [NUM_RGN-1:0] lo_we,
    output logic [NUM_RGN-1:0] hi_we,
    output sel_t               sel
);
    localparam logic [OFF_W-1:0] SPAN = OFF_W'(2 * NUM_RGN);

    logic             mine;
    logic [OFF_W-1:0] rel;
    logic             in_map;

    always_comb begin
        mine   = valid && (req.port == BANK_PORT);
        rel    = req.off - BASE_OFF;
        in_map = (req.off >= BASE_OFF) && (rel < SPAN);
        sel.acc  = mine && !req.wr;
        sel.hit  = in_map;
        sel.high = rel[0];
        sel.idx  = rel[OFF_W-1:1];
    end

    for (genvar k = 0; k < NUM_RGN; k++) begin : g_we
        logic this_rgn;
        assign this_rgn = mine && req.wr && in_map && (sel.idx == (OFF_W-1)'(k));
        assign lo_we[k] = this_rgn && !sel.high;
        assign hi_we[k] = this_rgn && sel.high;
    end
endmodule

// File: rtl/lrb_region.sv
`timescale 1ns/1ps
module lrb_region
    import lrb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  lo_we,
    input  logic  hi_we,
    input  word_t wdata,
    output adr_t  base_q,
    output adr_t  end_q,
    output logic  locked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            end_q  <= '0;
            locked <= 1'b0;
        end else if (!locked) begin
            if (lo_we) begin
                base_q <= wdata[DATA_W-1:TAG_W];
                if (is_lock_tag(wdata[TAG_W-1:0]))
                    locked <= 1'b1;
            end
            if (hi_we)
                end_q <= wdata[DATA_W-1:TAG_W];
        end
    end
endmodule

// File: rtl/lrb_readback.sv
`timescale 1ns/1ps
module lrb_readback
    import lrb_pkg::*;
#(
    parameter int NUM_RGN = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  sel_t               sel,
    input  adr_t               base_a [NUM_RGN],
    input  adr_t               end_a  [NUM_RGN],
    input  logic [NUM_RGN-1:0] lk,
    output logic               rsp_valid,
    output word_t              rsp_rdata
);
    word_t rd_next;

    always_comb begin
        rd_next = '0;
        for (int k = 0; k < NUM_RGN; k++) begin
            if (sel.hit && sel.idx == (OFF_W-1)'(k))
                rd_next = sel.high ? pack_read(end_a[k], lk[k])
                                   : pack_read(base_a[k], lk[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= sel.acc;
            if (sel.acc)
                rsp_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/lrb_bank.sv
`timescale 1ns/1ps
module lrb_bank
    import lrb_pkg::*;
#(
    parameter int                NUM_RGN   = 3,
    parameter logic [PORT_W-1:0] BANK_PORT = 8'h03,
    parameter logic [OFF_W-1:0]  BASE_OFF  = 8'h10
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      msg_valid,
    input  logic                      msg_write,
    input  logic [PORT_W-1:0]         msg_port,
    input  logic [OFF_W-1:0]          msg_offset,
    input  logic [DATA_W-1:0]         msg_wdata,
    output logic                      rsp_valid,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic [NUM_RGN*DATA_W-1:0] rgn_base,
    output logic [NUM_RGN*DATA_W-1:0] rgn_end,
    output logic [NUM_RGN-1:0]        rgn_locked
);
    req_t               req;
    sel_t               sel;
    logic [NUM_RGN-1:0] lo_we, hi_we;
    adr_t               base_a [NUM_RGN];
    adr_t               end_a  [NUM_RGN];

    assign req = '{wr: msg_write, port: msg_port, off: msg_offset};

    lrb_decode #(
        .NUM_RGN(NUM_RGN), .BANK_PORT(BANK_PORT), .BASE_OFF(BASE_OFF)
    ) u_dec (
        .valid(msg_valid), .req(req), .lo_we(lo_we), .hi_we(hi_we), .sel(sel)
    );

    for (genvar k = 0; k < NUM_RGN; k++) begin : g_rgn
        lrb_region u_rgn (
            .clk(clk), .rst(rst),
            .lo_we(lo_we[k]), .hi_we(hi_we[k]), .wdata(msg_wdata),
            .base_q(base_a[k]), .end_q(end_a[k]), .locked(rgn_locked[k])
        );
        assign rgn_base[k*DATA_W +: DATA_W] = to_word(base_a[k]);
        assign rgn_end[k*DATA_W +: DATA_W]  = to_word(end_a[k]);
    end

    lrb_readback #(.NUM_RGN(NUM_RGN)) u_rd (
        .clk(clk), .rst(rst), .sel(sel),
        .base_a(base_a), .end_a(end_a), .lk(rgn_locked),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );
endmodule

// File: rtl/lrb_bank_chk.sv
`timescale 1ns/1ps
module lrb_bank_chk
    import lrb_pkg::*;
#(
    parameter int                NUM_RGN   = 3,
    parameter logic [PORT_W-1:0] BANK_PORT = 8'h03,
    parameter logic [OFF_W-1:0]  BASE_OFF  = 8'h10
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      msg_valid,
    input logic                      msg_write,
    input logic [PORT_W-1:0]         msg_port,
    input logic [OFF_W-1:0]          msg_offset,
    input logic [TAG_W-1:0]          wtag,
    input logic                      rsp_valid,
    input logic [DATA_W-1:0]         rsp_rdata,
    input logic [NUM_RGN*DATA_W-1:0] rgn_base,
    input logic [NUM_RGN*DATA_W-1:0] rgn_end,
    input logic [NUM_RGN-1:0]        rgn_locked
);
    localparam logic [OFF_W-1:0] SPAN = OFF_W'(2 * NUM_RGN);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (rgn_locked == '0) && !rsp_valid);

    p_foreign_port_r2: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_port != BANK_PORT) |=> !rsp_valid);

    p_read_rsp_r4: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_write && msg_port == BANK_PORT) |=> rsp_valid);

    p_out_range_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_write && msg_port == BANK_PORT &&
         (msg_offset < BASE_OFF || msg_offset >= BASE_OFF + SPAN))
        |=> rsp_rdata == '0);

    p_write_no_rsp_r10: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_write) |=> !rsp_valid);

    for (genvar k = 0; k < NUM_RGN; k++) begin : g_chk
        p_lock_sticky_r8: assert property (@(posedge clk) disable iff (rst)
            rgn_locked[k] |=> rgn_locked[k]);

        p_locked_frozen_r7: assert property (@(posedge clk) disable iff (rst)
            rgn_locked[k] |=> $stable(rgn_base[k*DATA_W +: DATA_W]) &&
                              $stable(rgn_end[k*DATA_W +: DATA_W]));

        p_lock_cause_r5: assert property (@(posedge clk) disable iff (rst)
            $rose(rgn_locked[k]) |-> $past(msg_valid && msg_write &&
                msg_port == BANK_PORT &&
                msg_offset == BASE_OFF + OFF_W'(2 * k) && wtag == '0));
    end
endmodule

bind lrb_bank lrb_bank_chk #(
    .NUM_RGN(NUM_RGN), .BANK_PORT(BANK_PORT), .BASE_OFF(BASE_OFF)
) u_chk (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_write(msg_write),
    .msg_port(msg_port), .msg_offset(msg_offset), .wtag(msg_wdata[3:0]),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rgn_base(rgn_base), .rgn_end(rgn_end), .rgn_locked(rgn_locked)
);

// File: tb/lrb_bank_test.sv
`timescale 1ns/1ps
module lrb_bank_test;
    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        msg_valid = 1'b0;
    logic        msg_write = 1'b0;
    logic [7:0]  msg_port = '0;
    logic [7:0]  msg_offset = '0;
    logic [31:0] msg_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [N*32-1:0] rgn_base, rgn_end;
    logic [N-1:0]    rgn_locked;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_base [N];
    logic [31:0] m_end  [N];
    logic        m_lk   [N];

    lrb_bank uut (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_write(msg_write),
        .msg_port(msg_port), .msg_offset(msg_offset), .msg_wdata(msg_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rgn_base(rgn_base), .rgn_end(rgn_end), .rgn_locked(rgn_locked)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < N; k++) begin
            m_base[k] = '0; m_end[k] = '0; m_lk[k] = 1'b0;
        end
    endtask

    task automatic model_write(input logic [7:0] port, input logic [7:0] off, input logic [31:0] d);
        int k;
        if (port != 8'h03 || off < 8'h10 || off > 8'h15) return;
        k = (off - 8'h10) / 2;
        if (m_lk[k]) return;
        if (off[0] == 1'b0) begin
            m_base[k] = d & 32'hFFFF_FFF0;
            if (d[3:0] == 4'h0) m_lk[k] = 1'b1;
        end else begin
            m_end[k] = d & 32'hFFFF_FFF0;
        end
    endtask

    task automatic compare_all(input string req);
        for (int k = 0; k < N; k++) begin
            check(req, rgn_base[k*32 +: 32], m_base[k]);
            check(req, rgn_end[k*32 +: 32], m_end[k]);
            check(req, {31'b0, rgn_locked[k]}, {31'b0, m_lk[k]});
        end
    endtask

    task automatic do_write(input logic [7:0] port, input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        msg_valid = 1'b1; msg_write = 1'b1; msg_port = port; msg_offset = off; msg_wdata = d;
        @(negedge clk);
        msg_valid = 1'b0; msg_write = 1'b0;
        model_write(port, off, d);
        check("R10", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic do_read(input logic [7:0] port, input logic [7:0] off,
                           output logic v, output logic [31:0] d);
        @(negedge clk);
        msg_valid = 1'b1; msg_write = 1'b0; msg_port = port; msg_offset = off;
        @(negedge clk);
        v = rsp_valid; d = rsp_rdata;
        msg_valid = 1'b0;
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] off);
        int k;
        if (off < 8'h10 || off > 8'h15) return 32'h0;
        k = (off - 8'h10) / 2;
        return (off[0] ? m_end[k] : m_base[k]) | {31'b0, m_lk[k]};
    endfunction

    task automatic read_check(input string req, input logic [7:0] off);
        logic v; logic [31:0] d;
        do_read(8'h03, off, v, d);
        check(req, {31'b0, v}, 32'd1);
        check(req, d, exp_read(off));
    endtask

    task automatic apply_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        model_clear();
    endtask

    task automatic t_reset();
        check("R1", {31'b0, rsp_valid}, 32'd0);
        compare_all("R1");
        read_check("R1", 8'h10);
    endtask

    task automatic t_map();
        for (int k = 0; k < N; k++) begin
            do_write(8'h03, 8'(8'h10 + 2*k), 32'h1000_0007 + 32'(k) * 32'h0110_0000);
            do_write(8'h03, 8'(8'h11 + 2*k), 32'h1FFF_FFFF - 32'(k) * 32'h0001_0000);
        end
        compare_all("R3");
        compare_all("R6");
        for (int o = 8'h10; o <= 8'h15; o++) read_check("R4", 8'(o));
    endtask

    task automatic t_port();
        logic v; logic [31:0] d;
        do_write(8'h02, 8'h12, 32'hDEAD_BEE0);
        do_write(8'h04, 8'h13, 32'hCAFE_0005);
        compare_all("R2");
        do_read(8'h02, 8'h12, v, d);
        check("R2", {31'b0, v}, 32'd0);
    endtask

    task automatic t_range();
        do_write(8'h03, 8'h0F, 32'h5555_0000);
        do_write(8'h03, 8'h16, 32'h6666_0000);
        do_write(8'h03, 8'h30, 32'h7777_0003);
        compare_all("R9");
        read_check("R9", 8'h0F);
        read_check("R9", 8'h16);
    endtask

    task automatic t_lock();
        do_write(8'h03, 8'h12, 32'h2000_0000);
        check("R5", {31'b0, rgn_locked[1]}, 32'd1);
        check("R5", rgn_base[32 +: 32], 32'h2000_0000);
        compare_all("R5");
        read_check("R5", 8'h12);
        read_check("R4", 8'h13);
    endtask

    task automatic t_frozen();
        do_write(8'h03, 8'h12, 32'h3333_3335);
        do_write(8'h03, 8'h13, 32'h4444_4440);
        check("R7", rgn_base[32 +: 32], 32'h2000_0000);
        do_write(8'h03, 8'h10, 32'h0ABC_0009);
        do_write(8'h03, 8'h15, 32'h0DEF_0001);
        compare_all("R7");
    endtask

    task automatic t_sticky();
        do_write(8'h03, 8'h12, 32'h0000_000F);
        check("R8", {31'b0, rgn_locked[1]}, 32'd1);
        do_write(8'h03, 8'h14, 32'h7000_0000);
        compare_all("R8");
        apply_reset();
        check("R8", {29'b0, rgn_locked}, 32'd0);
        compare_all("R1");
        do_write(8'h03, 8'h13, 32'h9000_00F1);
        compare_all("R3");
    endtask

    initial begin
        #250000;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_port();
        t_range();
        t_lock();
        t_frozen();
        t_sticky();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule